// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

This block is the combinational execute stage of a simple 32-bit datapath. One adder/subtractor, one four-function logic unit and one staged barrel shifter work on the same pair of operands, and a final selector hands out the output of whichever unit the function class names. A zero flag is raised whenever that output is all zeros, so a branch unit can test equality after a subtract.

An 8-bit control word drives everything. Two bits pick the function class. One bit picks add or subtract. Three bits steer the shifter: two of them give the shift kind and one picks where the amount comes from. Two more bits pick the logic function. The shifter moves the second operand. Its amount is either a 5-bit constant field that comes with the instruction, or the low bits of the first operand, which serves as a register-held count. The shifter has five stages. Each stage either shifts by a power of two or passes its input through, under one bit of the amount.

Control word layout: bits [7:6] class, bit [5] subtract, bits [4:3] shift kind, bit [2] variable amount, bits [1:0] logic function.

Top module: `multifunc_alu`

## Requirements
- R1: The class field ctrl[7:6] selects the output: 00 shifter, 01 set-less-than, 10 add/subtract, 11 logic unit.
- R2: In the add/subtract class, ctrl[5]=0 gives opA+opB and ctrl[5]=1 gives opA-opB, both modulo 2^32.
- R3: In the logic class, ctrl[1:0] selects 00 AND, 01 OR, 10 XOR, 11 NOR of opA and opB.
- R4: In the shift class, ctrl[4:3]=01 shifts opB left and 10 shifts it right, filling with zeros.
- R5: In the shift class, ctrl[4:3]=11 shifts opB right and fills every vacated bit with a copy of opB[31].
- R6: ctrl[2]=0 takes the shift amount from shamtImm. ctrl[2]=1 takes it from opA[4:0], and opA[31:5] have no effect.
- R7: In the shift class, ctrl[4:3]=00 passes opB through unchanged, whatever the amount.
- R8: The set-less-than class returns 1 when opA is less than opB as signed 32-bit numbers, and 0 otherwise. The result stays correct when the difference overflows, and ctrl[5] is ignored.
- R9: zero is 1 exactly when all 32 result bits are 0.
- R10: Control fields that belong to a class other than the one selected have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; its low 5 bits are the variable shift amount |
| opB | input | 32 | Second operand; the value that is shifted |
| shamtImm | input | 5 | Constant shift amount |
| ctrl | input | 8 | Control word, laid out as stated above |
| result | output | 32 | Selected unit output |
| zero | output | 1 | Result-is-zero flag |

## Verification
The adder serves two classes: it produces sums and differences for arithmetic, and it produces the sign-with-overflow decision for set-less-than. Both uses can be demanded by the same operand pair. The bench provokes this by applying identical operands under both classes, including pairs whose difference overflows such as 0x80000000 against 1. The set-less-than verdict is judged against a signed comparison, and the difference is judged against plain modular subtraction. The shifter's two amount sources are also set against each other: the constant field and opA hold different values in the same cycle, so picking the wrong source shows up in the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } cls_e;

  typedef enum logic [1:0] {
    SHK_NONE = 2'b00,
    SHK_LEFT = 2'b01,
    SHK_RLOG = 2'b10,
    SHK_RARI = 2'b11
  } shk_e;

  typedef enum logic [1:0] {
    LGF_AND = 2'b00,
    LGF_OR  = 2'b01,
    LGF_XOR = 2'b10,
    LGF_NOR = 2'b11
  } lgf_e;

  // Strobes from control decode to the datapath
  typedef struct packed {
    logic selShift;
    logic selSlt;
    logic selArith;
    logic selLogic;
    logic subtract;
    logic shBypass;
    logic shLeft;
    logic shArith;
    logic useVarAmt;
    lgf_e logicFn;
  } alu_strobe_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [7:0]  ctrl,
  output alu_strobe_t strobes
);

  cls_e classSel;
  shk_e shiftKind;

  assign classSel  = cls_e'(ctrl[7:6]);
  assign shiftKind = shk_e'(ctrl[4:3]);

  always_comb begin
    strobes           = '0;
    strobes.selShift  = (classSel == CLS_SHIFT);
    strobes.selSlt    = (classSel == CLS_SLT);
    strobes.selArith  = (classSel == CLS_ARITH);
    strobes.selLogic  = (classSel == CLS_LOGIC);
    // set-less-than always needs the difference
    strobes.subtract  = ctrl[5] | (classSel == CLS_SLT);
    strobes.shBypass  = (shiftKind == SHK_NONE);
    strobes.shLeft    = (shiftKind == SHK_LEFT);
    strobes.shArith   = (shiftKind == SHK_RARI);
    strobes.useVarAmt = ctrl[2];
    strobes.logicFn   = lgf_e'(ctrl[1:0]);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SHW-1:0]   amount,
  input  logic             shiftLeft,
  input  logic             fillSign,
  output logic [WIDTH-1:0] dataOut
);

  logic             fillBit;
  logic [WIDTH-1:0] stage [SHW+1];

  assign fillBit  = fillSign & dataIn[WIDTH-1];
  assign stage[0] = dataIn;

  // Stage s moves by 2**s when bit s of the amount is set
  for (genvar s = 0; s < SHW; s++) begin : gStage
    localparam int STEP = 1 << s;
    logic [WIDTH-1:0] movedLeft;
    logic [WIDTH-1:0] movedRight;
    assign movedLeft  = {stage[s][WIDTH-1-STEP:0], {STEP{1'b0}}};
    assign movedRight = {{STEP{fillBit}}, stage[s][WIDTH-1:STEP]};
    assign stage[s+1] = !amount[s] ? stage[s]
                      : (shiftLeft ? movedLeft : movedRight);
  end

  assign dataOut = stage[SHW];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamtImm,
  input  alu_strobe_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  logic [WIDTH-1:0] addendB;
  logic [WIDTH:0]   sumExt;
  logic [WIDTH-1:0] sumOut;
  logic             overflow;
  logic             lessThan;
  logic [WIDTH-1:0] logicOut;
  logic [SHW-1:0]   amtSel;
  logic [SHW-1:0]   amtEff;
  logic [WIDTH-1:0] shiftOut;

  // Adder / subtractor: x + ~y + 1 for subtract
  assign addendB  = opB ^ {WIDTH{strobes.subtract}};
  assign sumExt   = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, strobes.subtract};
  assign sumOut   = sumExt[WIDTH-1:0];
  assign overflow = (opA[WIDTH-1] == addendB[WIDTH-1]) && (sumOut[WIDTH-1] != opA[WIDTH-1]);
  assign lessThan = sumOut[WIDTH-1] ^ overflow;

  always_comb begin
    unique case (strobes.logicFn)
      LGF_AND: logicOut = opA & opB;
      LGF_OR:  logicOut = opA | opB;
      LGF_XOR: logicOut = opA ^ opB;
      LGF_NOR: logicOut = ~(opA | opB);
      default: logicOut = '0;
    endcase
  end

  assign amtSel = strobes.useVarAmt ? opA[SHW-1:0] : shamtImm;
  assign amtEff = strobes.shBypass ? '0 : amtSel;

  alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) uShifter (
    .dataIn    (opB),
    .amount    (amtEff),
    .shiftLeft (strobes.shLeft),
    .fillSign  (strobes.shArith),
    .dataOut   (shiftOut)
  );

  always_comb begin
    if (strobes.selLogic)      result = logicOut;
    else if (strobes.selArith) result = sumOut;
    else if (strobes.selSlt)   result = {{(WIDTH-1){1'b0}}, lessThan};
    else                       result = shiftOut;
  end

  assign zero = ~|result;

  // selShift is implied by the fall-through of the selector
  logic unusedShiftSel;
  assign unusedShiftSel = strobes.selShift;

endmodule

// File: rtl/multifunc_alu.sv
module multifunc_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamtImm,
  input  logic [7:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  alu_strobe_t strobes;

  alu_control uControl (
    .ctrl    (ctrl),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH), .SHW(SHW)) uDatapath (
    .opA      (opA),
    .opB      (opB),
    .shamtImm (shamtImm),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero)
  );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       ctrlClass,
  input logic             ctrlSub,
  input logic [1:0]       ctrlShift,
  input logic [1:0]       ctrlLogic,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  logic known;
  assign known = !$isunknown({opA, opB, ctrlClass, ctrlSub, ctrlShift, ctrlLogic});

  always_comb begin
    if (known) begin
      AST_SUB_DIFF: assert (!(ctrlClass == 2'b10 && ctrlSub) || result == opA - opB)
        else $error("subtract result mismatch"); // R2
      AST_AND_SUBSET: assert (!(ctrlClass == 2'b11 && ctrlLogic == 2'b00) || (result & ~opA) == '0)
        else $error("AND result has bits outside opA"); // R3
      AST_SRA_SIGN: assert (!(ctrlClass == 2'b00 && ctrlShift == 2'b11 && opB[WIDTH-1]) || result[WIDTH-1])
        else $error("arithmetic shift lost the sign"); // R5
      AST_SHIFT_NONE: assert (!(ctrlClass == 2'b00 && ctrlShift == 2'b00) || result == opB)
        else $error("no-shift did not pass opB"); // R7
      AST_SLT_BINARY: assert (ctrlClass != 2'b01 || result[WIDTH-1:1] == '0)
        else $error("set-less-than upper bits set"); // R8
      AST_ZERO_FLAG: assert (zero == (result == '0))
        else $error("zero flag disagrees with result"); // R9
    end
  end

endmodule

bind multifunc_alu alu_checker #(.WIDTH(WIDTH)) uChecker (
  .opA       (opA),
  .opB       (opB),
  .ctrlClass (ctrl[7:6]),
  .ctrlSub   (ctrl[5]),
  .ctrlShift (ctrl[4:3]),
  .ctrlLogic (ctrl[1:0]),
  .result    (result),
  .zero      (zero)
);

// File: tb/multifunc_alu_test.sv
module multifunc_alu_test;

  logic        clk = 1'b0;
  logic [31:0] opA;
  logic [31:0] opB;
  logic [4:0]  shamtImm;
  logic [7:0]  ctrl;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  multifunc_alu uut (
    .opA(opA), .opB(opB), .shamtImm(shamtImm), .ctrl(ctrl),
    .result(result), .zero(zero)
  );

  // {ctrl, opA, opB, shamtImm, expected}
  localparam int NV = 17;
  localparam logic [108:0] VECS [NV] = '{
    {8'b10_0_00_0_00, 32'h00000005, 32'h00000007, 5'd0,  32'h0000000C}, // R2 add
    {8'b10_1_00_0_00, 32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE}, // R2 sub
    {8'b10_0_00_0_00, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000}, // R2 wrap
    {8'b11_0_00_0_00, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000}, // R3 AND
    {8'b11_0_00_0_01, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hFFF0FFF0}, // R3 OR
    {8'b11_0_00_0_10, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h0FF00FF0}, // R3 XOR
    {8'b11_0_00_0_11, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h000F000F}, // R3 NOR
    {8'b00_0_01_0_00, 32'h00000000, 32'h00000001, 5'd31, 32'h80000000}, // R4 left
    {8'b00_0_10_0_00, 32'h00000000, 32'h80000000, 5'd4,  32'h08000000}, // R4 right
    {8'b00_0_11_0_00, 32'h00000000, 32'h80000000, 5'd4,  32'hF8000000}, // R5 sra
    {8'b00_0_11_1_00, 32'hFFFFFF23, 32'h80000010, 5'd0,  32'hF0000002}, // R6 var
    {8'b00_0_01_1_00, 32'h00000020, 32'h12345678, 5'd7,  32'h12345678}, // R6 var 0
    {8'b00_0_00_0_00, 32'h00000000, 32'hDEADBEEF, 5'd5,  32'hDEADBEEF}, // R7 none
    {8'b01_0_00_0_00, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001}, // R8
    {8'b01_0_00_0_00, 32'h80000000, 32'h00000001, 5'd0,  32'h00000001}, // R8 ovf
    {8'b01_1_00_0_00, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h00000000}, // R8
    {8'b10_0_11_1_11, 32'h00000005, 32'h00000007, 5'd9,  32'h0000000C}  // R10
  };

  function automatic logic [31:0] model(logic [7:0] c, logic [31:0] a,
                                        logic [31:0] b, logic [4:0] sh);
    logic [4:0] amt;
    amt = c[2] ? a[4:0] : sh;
    case (c[7:6])
      2'b00: case (c[4:3])
               2'b00:   return b;
               2'b01:   return b << amt;
               2'b10:   return b >> amt;
               default: return 32'($signed(b) >>> amt);
             endcase
      2'b01: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      2'b10: return c[5] ? a - b : a + b;
      default: case (c[1:0])
                 2'b00:   return a & b;
                 2'b01:   return a | b;
                 2'b10:   return a ^ b;
                 default: return ~(a | b);
               endcase
    endcase
  endfunction

  task automatic apply(logic [7:0] c, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    @(posedge clk);
    ctrl = c; opA = a; opB = b; shamtImm = sh;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
          fails++; checks++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
      begin : main
        // Quiet state: all inputs zero
        apply(8'h00, 32'h0, 32'h0, 5'd0);
        check("reset R7 result", result, 32'h0);
        check("reset R9 zero", {31'b0, zero}, 32'd1);

        for (int i = 0; i < NV; i++) begin
          logic [108:0] v;
          v = VECS[i];
          apply(v[108:101], v[100:69], v[68:37], v[36:32]);
          check($sformatf("vector %0d result", i), result, v[31:0]);
          check($sformatf("vector %0d R9 zero", i), {31'b0, zero}, {31'b0, v[31:0] == 32'h0});
        end

        // R1: one operand pair under all four classes
        for (int k = 0; k < 4; k++) begin
          logic [7:0] c;
          c = {k[1:0], 6'b1_01_0_10};
          apply(c, 32'h80000000, 32'h00000001, 5'd3);
          check($sformatf("R1 class %0d", k), result, model(c, 32'h80000000, 32'h00000001, 5'd3));
        end

        // R8 sub bit ignored; R2 same pair gives wraparound difference
        apply(8'b01_1_00_0_00, 32'h80000000, 32'h00000001, 5'd0);
        check("R8 sub bit set", result, 32'd1);
        apply(8'b10_1_00_0_00, 32'h80000000, 32'h00000001, 5'd0);
        check("R2 overflowing difference", result, 32'h7FFFFFFF);

        // R6: constant and variable amounts disagree
        apply(8'b00_0_10_0_00, 32'hFFFFFFE1, 32'hF0000000, 5'd8);
        check("R6 constant amount", result, 32'h00F00000);
        apply(8'b00_0_10_1_00, 32'hFFFFFFE1, 32'hF0000000, 5'd8);
        check("R6 variable amount", result, 32'h78000000);

        // R5 positive value, full shift
        apply(8'b00_0_11_0_00, 32'h0, 32'h7FFFFFFF, 5'd31);
        check("R5 positive sra", result, 32'h0);
        apply(8'b00_0_11_0_00, 32'h0, 32'h80000000, 5'd31);
        check("R5 negative sra", result, 32'hFFFFFFFF);

        // R10: foreign fields on the logic class
        apply(8'b11_1_11_1_10, 32'h0000FFFF, 32'h00FF00FF, 5'd17);
        check("R10 logic with foreign fields", result, 32'h00FFFF00);

        // Random sweep against the model (R1..R10)
        for (int i = 0; i < 3000; i++) begin
          logic [7:0]  c;
          logic [31:0] a, b;
          logic [4:0]  sh;
          c = 8'($urandom); a = $urandom; b = $urandom; sh = 5'($urandom);
          if (i % 7 == 0) b = {b[31], 31'h0};
          if (i % 11 == 0) b = a;
          apply(c, a, b, sh);
          check($sformatf("random R1 ctrl %h", c), result, model(c, a, b, sh));
          check("random R9 zero", {31'b0, zero}, {31'b0, model(c, a, b, sh) == 32'h0});
        end
        done = 1'b1;
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule